// File: doc/BRIEF.md
# Set-Associative Write-Back Data Cache

This block is a small data cache placed between a processor load/store port and a word-addressed backing memory. The processor issues single-word reads and writes with a valid/ready handshake. Each completed request is reported with a one-cycle response strobe, and read data travels with that strobe. Toward memory the cache moves whole blocks, and every transfer is one request held until an acknowledge pulse.

Each set holds a parameterised number of ways (2 or 4). A block is 32 to 128 bytes and is stored as words. Read misses and write misses both allocate. Writes change only the cached copy and mark the block dirty. A dirty block goes back to memory only when it is chosen as a victim, and that full-block write finishes before the refill read is issued. A free way is preferred when placing a new block. When every way is valid, the way that has gone unused for the longest time is replaced.

Only one miss is handled at a time. The processor port reports not-ready from the cycle after a miss is accepted until the response for that miss is delivered.

Top module: `sa_wb_cache`

## Requirements
- R1: The word address is split from the least significant end: the low log2(words per block) bits select the word in the block, the next log2(SETS) bits select the set, and the remaining upper bits form the tag. The memory block address is the tag concatenated above the set index.
- R2: A request that hits is answered with `cpu_resp_valid` in the cycle right after acceptance, and it causes no memory transfer.
- R3: A read miss fetches the block from memory and installs it, so a later access to any word of that block hits.
- R4: A write hit updates only the cached word and marks the block dirty. The backing memory keeps its old value.
- R5: A write miss fetches and installs the block, merges the written word into it, and marks the block dirty.
- R6: On a miss, the lowest-numbered invalid way of the set is filled if one exists.
- R7: When the victim is dirty, its whole block is written to memory at the victim's block address before the refill read is issued. A clean or invalid victim causes no memory write.
- R8: Every hit and every completed refill makes that way the most recently used way in its set. When all ways are valid, the least recently used way is the victim.
- R9: Reset leaves every way invalid and clean, with the processor port ready, no response pending and no memory request.
- R10: `mem_req` stays high with stable `mem_we` and `mem_addr` until `mem_ack` pulses, and each acknowledge completes exactly one block transfer.
- R11: While a miss is being serviced, `cpu_ready` is low, so at most one request is outstanding.
- R12: A read returns the value of the most recent write to that address. If there was no such write, it returns the initial memory content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request valid |
| cpu_ready | output | 1 | Cache can accept a request this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_resp_valid | output | 1 | One-cycle strobe: request completed |
| cpu_rdata | output | DATA_W | Read data, valid with the response strobe |
| mem_req | output | 1 | Block transfer request, held until acknowledge |
| mem_we | output | 1 | 1 = block write to memory, 0 = block read |
| mem_addr | output | ADDR_W-log2(words per block) | Block address (tag, set index) |
| mem_wdata | output | words per block x DATA_W | Block written to memory, word 0 in the low bits |
| mem_ack | input | 1 | One-cycle acknowledge that ends a transfer |
| mem_rdata | input | words per block x DATA_W | Block read from memory, valid with the acknowledge |

## Verification
The bench first goes after the eviction corner cases. A dirty victim must produce one write of the old block at the old tag's address, followed by a read of the new block. A cache that skipped the write-back, wrote only part of the block, or issued the refill first would leave stale words in memory or load the wrong block. Victim choice is probed by touching the older way of a full set before the next conflicting miss. An LRU that ignored hits would evict the block that was just used. Ignoring invalid ways would evict live data while an empty way remained. Write hits are checked against the backing memory, which must not change. Write misses are followed by a read of the same word: a design that failed to merge the word would return the stale memory value.

// File: rtl/cache_pkg.sv
package cache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WB_RD  = 3'd1,
    ST_WB_REQ = 3'd2,
    ST_RF_REQ = 3'd3,
    ST_RF_WR  = 3'd4
  } cache_state_e;

endpackage

// File: rtl/cache_data_ram.sv
module cache_data_ram #(
  parameter int DATA_W = 32,
  parameter int AW     = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store_q[waddr] <= wdata;
    rdata <= store_q[raddr];
  end

endmodule

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int WAYS  = 2,
  parameter int SETS  = 4,
  parameter int TAG_W = 7
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [$clog2(SETS)-1:0]     lk_idx,
  input  logic [TAG_W-1:0]            lk_tag,
  output logic [WAYS-1:0]             hit_vec,
  output logic                        lk_hit,
  output logic [$clog2(WAYS)-1:0]     hit_way,
  output logic                        free_any,
  output logic [$clog2(WAYS)-1:0]     free_way,
  output logic [WAYS-1:0][TAG_W-1:0]  way_tag,
  output logic [WAYS-1:0]             way_dirty,
  input  logic                        dirty_set,
  input  logic [$clog2(WAYS)-1:0]     dirty_way,
  input  logic [$clog2(SETS)-1:0]     dirty_idx,
  input  logic                        fill_en,
  input  logic [$clog2(WAYS)-1:0]     fill_way,
  input  logic [$clog2(SETS)-1:0]     fill_idx,
  input  logic [TAG_W-1:0]            fill_tag,
  input  logic                        fill_dirty
);
  localparam int WAY_W = $clog2(WAYS);

  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  dirty_q [SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else begin
      if (fill_en) begin
        valid_q[fill_idx][fill_way] <= 1'b1;
        dirty_q[fill_idx][fill_way] <= fill_dirty;
      end
      if (dirty_set) dirty_q[dirty_idx][dirty_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_idx][fill_way] <= fill_tag;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign way_tag[w]   = tag_q[lk_idx][w];
    assign way_dirty[w] = dirty_q[lk_idx][w];
    assign hit_vec[w]   = valid_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
  end

  assign lk_hit   = |hit_vec;
  assign free_any = ~&valid_q[lk_idx];

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  always_comb begin
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!valid_q[lk_idx][w]) free_way = WAY_W'(w);
  end

endmodule

// File: rtl/cache_lru.sv
module cache_lru #(
  parameter int WAYS = 2,
  parameter int SETS = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [$clog2(SETS)-1:0] rd_idx,
  output logic [$clog2(WAYS)-1:0] oldest_way,
  input  logic                    touch_en,
  input  logic [$clog2(SETS)-1:0] touch_idx,
  input  logic [$clog2(WAYS)-1:0] touch_way
);
  localparam int WAY_W = $clog2(WAYS);

  // age 0 = most recently used, WAYS-1 = least recently used
  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [WAY_W-1:0] cur_age;

  assign cur_age = age_q[touch_idx][touch_way];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age_q[touch_idx][w] <= '0;
        else if (age_q[touch_idx][w] < cur_age)
          age_q[touch_idx][w] <= age_q[touch_idx][w] + 1'b1;
      end
    end
  end

  always_comb begin
    oldest_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (age_q[rd_idx][w] == WAY_W'(WAYS - 1)) oldest_way = WAY_W'(w);
  end

endmodule

// File: rtl/sa_wb_cache.sv
module sa_wb_cache
  import cache_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int WAYS      = 2,
  parameter int BLK_BYTES = 32,
  parameter int SETS      = 4
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   cpu_valid,
  output logic                                   cpu_ready,
  input  logic                                   cpu_we,
  input  logic [ADDR_W-1:0]                      cpu_addr,
  input  logic [DATA_W-1:0]                      cpu_wdata,
  output logic                                   cpu_resp_valid,
  output logic [DATA_W-1:0]                      cpu_rdata,
  output logic                                   mem_req,
  output logic                                   mem_we,
  output logic [ADDR_W-$clog2(BLK_BYTES*8/DATA_W)-1:0] mem_addr,
  output logic [BLK_BYTES*8-1:0]                 mem_wdata,
  input  logic                                   mem_ack,
  input  logic [BLK_BYTES*8-1:0]                 mem_rdata
);
  localparam int WORDS   = BLK_BYTES * 8 / DATA_W;
  localparam int OFF_W   = $clog2(WORDS);
  localparam int IDX_W   = $clog2(SETS);
  localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;
  localparam int WAY_W   = $clog2(WAYS);
  localparam int BLK_W   = WORDS * DATA_W;
  localparam int BADDR_W = ADDR_W - OFF_W;
  localparam int RAM_AW  = WAY_W + IDX_W + OFF_W;
  localparam int CNT_W   = OFF_W + 1;

  function automatic logic [DATA_W-1:0] pick_word(input logic [BLK_W-1:0] blk,
                                                  input logic [OFF_W-1:0] sel);
    pick_word = '0;
    for (int i = 0; i < WORDS; i++)
      if (sel == OFF_W'(i)) pick_word = blk[i*DATA_W +: DATA_W];
  endfunction

  // address fields of the incoming request
  logic [OFF_W-1:0] cpu_off;
  logic [IDX_W-1:0] cpu_idx;
  logic [TAG_W-1:0] cpu_tag;
  assign cpu_off = cpu_addr[OFF_W-1:0];
  assign cpu_idx = cpu_addr[OFF_W +: IDX_W];
  assign cpu_tag = cpu_addr[ADDR_W-1 -: TAG_W];

  cache_state_e      state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              req_we_q;
  logic [OFF_W-1:0]  req_off_q;
  logic [IDX_W-1:0]  req_idx_q;
  logic [TAG_W-1:0]  req_tag_q;
  logic [DATA_W-1:0] req_wdata_q;
  logic [WAY_W-1:0]  vic_way_q;
  logic [TAG_W-1:0]  vic_tag_q;
  logic [BLK_W-1:0]  blk_buf_q;
  logic              resp_q;
  logic              rsel_q;
  logic [DATA_W-1:0] miss_rdata_q;

  // tag store and LRU interface
  logic [WAYS-1:0]            hit_vec;
  logic                       lk_hit;
  logic [WAY_W-1:0]           hit_way;
  logic                       free_any;
  logic [WAY_W-1:0]           free_way;
  logic [WAYS-1:0][TAG_W-1:0] way_tag;
  logic [WAYS-1:0]            way_dirty;
  logic                       dirty_set;
  logic                       fill_en;
  logic [WAY_W-1:0]           oldest_way;
  logic                       touch_en;
  logic [IDX_W-1:0]           touch_idx;
  logic [WAY_W-1:0]           touch_way;

  // data array interface
  logic              ram_we;
  logic [RAM_AW-1:0] ram_waddr;
  logic [DATA_W-1:0] ram_wdata;
  logic [RAM_AW-1:0] ram_raddr;
  logic [DATA_W-1:0] ram_q;

  logic             accept;
  logic             last_word;
  logic [WAY_W-1:0] vsel;

  assign accept    = cpu_valid && (state_q == ST_IDLE);
  assign last_word = (cnt_q == CNT_W'(WORDS - 1));
  assign vsel      = free_any ? free_way : oldest_way;

  cache_tag_store #(
    .WAYS (WAYS),
    .SETS (SETS),
    .TAG_W(TAG_W)
  ) u_tags (
    .clk       (clk),
    .rst       (rst),
    .lk_idx    (cpu_idx),
    .lk_tag    (cpu_tag),
    .hit_vec   (hit_vec),
    .lk_hit    (lk_hit),
    .hit_way   (hit_way),
    .free_any  (free_any),
    .free_way  (free_way),
    .way_tag   (way_tag),
    .way_dirty (way_dirty),
    .dirty_set (dirty_set),
    .dirty_way (hit_way),
    .dirty_idx (cpu_idx),
    .fill_en   (fill_en),
    .fill_way  (vic_way_q),
    .fill_idx  (req_idx_q),
    .fill_tag  (req_tag_q),
    .fill_dirty(req_we_q)
  );

  cache_lru #(
    .WAYS(WAYS),
    .SETS(SETS)
  ) u_lru (
    .clk       (clk),
    .rst       (rst),
    .rd_idx    (cpu_idx),
    .oldest_way(oldest_way),
    .touch_en  (touch_en),
    .touch_idx (touch_idx),
    .touch_way (touch_way)
  );

  cache_data_ram #(
    .DATA_W(DATA_W),
    .AW    (RAM_AW)
  ) u_data (
    .clk  (clk),
    .we   (ram_we),
    .waddr(ram_waddr),
    .wdata(ram_wdata),
    .raddr(ram_raddr),
    .rdata(ram_q)
  );

  // per-state control of the arrays
  always_comb begin
    ram_raddr = {hit_way, cpu_idx, cpu_off};
    ram_we    = 1'b0;
    ram_waddr = {vic_way_q, req_idx_q, cnt_q[OFF_W-1:0]};
    ram_wdata = pick_word(blk_buf_q, cnt_q[OFF_W-1:0]);
    dirty_set = 1'b0;
    fill_en   = 1'b0;
    touch_en  = 1'b0;
    touch_idx = cpu_idx;
    touch_way = hit_way;
    case (state_q)
      ST_IDLE: begin
        if (accept && lk_hit) begin
          touch_en = 1'b1;
          if (cpu_we) begin
            ram_we    = 1'b1;
            ram_waddr = {hit_way, cpu_idx, cpu_off};
            ram_wdata = cpu_wdata;
            dirty_set = 1'b1;
          end
        end
      end
      ST_WB_RD: begin
        ram_raddr = {vic_way_q, req_idx_q, cnt_q[OFF_W-1:0]};
      end
      ST_RF_WR: begin
        ram_we = 1'b1;
        if (req_we_q && (cnt_q[OFF_W-1:0] == req_off_q)) ram_wdata = req_wdata_q;
        if (last_word) begin
          fill_en   = 1'b1;
          touch_en  = 1'b1;
          touch_idx = req_idx_q;
          touch_way = vic_way_q;
        end
      end
      default: ;
    endcase
  end

  // control state
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      resp_q  <= 1'b0;
      rsel_q  <= 1'b0;
    end else begin
      resp_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (lk_hit) begin
              resp_q <= 1'b1;
              rsel_q <= 1'b0;
            end else begin
              cnt_q   <= '0;
              state_q <= (way_dirty[vsel] && !free_any) ? ST_WB_RD : ST_RF_REQ;
            end
          end
        end
        ST_WB_RD: begin
          if (cnt_q == CNT_W'(WORDS)) begin
            cnt_q   <= '0;
            state_q <= ST_WB_REQ;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_WB_REQ: begin
          if (mem_ack) state_q <= ST_RF_REQ;
        end
        ST_RF_REQ: begin
          if (mem_ack) begin
            cnt_q   <= '0;
            state_q <= ST_RF_WR;
          end
        end
        ST_RF_WR: begin
          if (last_word) begin
            resp_q  <= 1'b1;
            rsel_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // request, victim and block datapath
  always_ff @(posedge clk) begin
    if ((state_q == ST_IDLE) && accept && !lk_hit) begin
      req_we_q    <= cpu_we;
      req_off_q   <= cpu_off;
      req_idx_q   <= cpu_idx;
      req_tag_q   <= cpu_tag;
      req_wdata_q <= cpu_wdata;
      vic_way_q   <= vsel;
      vic_tag_q   <= way_tag[vsel];
    end
    if (state_q == ST_WB_RD) begin
      for (int i = 0; i < WORDS; i++)
        if (cnt_q == CNT_W'(i + 1)) blk_buf_q[i*DATA_W +: DATA_W] <= ram_q;
    end
    if ((state_q == ST_RF_REQ) && mem_ack) blk_buf_q <= mem_rdata;
    if ((state_q == ST_RF_WR) && last_word) miss_rdata_q <= pick_word(blk_buf_q, req_off_q);
  end

  assign cpu_ready      = (state_q == ST_IDLE);
  assign cpu_resp_valid = resp_q;
  assign cpu_rdata      = rsel_q ? miss_rdata_q : ram_q;

  assign mem_req   = (state_q == ST_WB_REQ) || (state_q == ST_RF_REQ);
  assign mem_we    = (state_q == ST_WB_REQ);
  assign mem_addr  = mem_we ? BADDR_W'({vic_tag_q, req_idx_q}) : BADDR_W'({req_tag_q, req_idx_q});
  assign mem_wdata = blk_buf_q;

endmodule

// File: rtl/cache_checker.sv
module cache_checker #(
  parameter int WAYS    = 2,
  parameter int BADDR_W = 9
) (
  input logic               clk,
  input logic               rst,
  input logic               cpu_valid,
  input logic               cpu_ready,
  input logic               cpu_resp_valid,
  input logic               mem_req,
  input logic               mem_we,
  input logic               mem_ack,
  input logic [BADDR_W-1:0] mem_addr,
  input logic [WAYS-1:0]    hit_vec,
  input logic               lookup_hit
);

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

  // R7
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

  // R11
  busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !cpu_ready);

  // R2
  hit_resp_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && cpu_ready && lookup_hit) |=> (cpu_resp_valid && !mem_req));

  // R1
  single_match_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

endmodule

bind sa_wb_cache cache_checker #(
  .WAYS   (WAYS),
  .BADDR_W(BADDR_W)
) u_cache_checker (
  .clk           (clk),
  .rst           (rst),
  .cpu_valid     (cpu_valid),
  .cpu_ready     (cpu_ready),
  .cpu_resp_valid(cpu_resp_valid),
  .mem_req       (mem_req),
  .mem_we        (mem_we),
  .mem_ack       (mem_ack),
  .mem_addr      (mem_addr),
  .hit_vec       (hit_vec),
  .lookup_hit    (lk_hit)
);

// File: tb/test_sa_wb_cache.sv
`timescale 1ns/1ps
module test_sa_wb_cache;
  localparam int AW    = 12;
  localparam int DW    = 32;
  localparam int NW    = 2;
  localparam int BB    = 32;
  localparam int NS    = 4;
  localparam int WORDS = BB * 8 / DW;
  localparam int OFF_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(NS);
  localparam int BAW   = AW - OFF_W;
  localparam int BLK_W = BB * 8;
  localparam int MEMSZ = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic             cpu_valid = 1'b0;
  logic             cpu_ready;
  logic             cpu_we = 1'b0;
  logic [AW-1:0]    cpu_addr = '0;
  logic [DW-1:0]    cpu_wdata = '0;
  logic             cpu_resp_valid;
  logic [DW-1:0]    cpu_rdata;
  logic             mem_req;
  logic             mem_we;
  logic [BAW-1:0]   mem_addr;
  logic [BLK_W-1:0] mem_wdata;
  logic             mem_ack;
  logic [BLK_W-1:0] mem_rdata;

  sa_wb_cache #(
    .ADDR_W(AW), .DATA_W(DW), .WAYS(NW), .BLK_BYTES(BB), .SETS(NS)
  ) i_sa_wb_cache (
    .clk(clk), .rst(rst),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_resp_valid(cpu_resp_valid), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [DW-1:0] init_word(int i);
    return (i * 32'h9E3779B1) ^ 32'h5A5A_0F0F;
  endfunction

  // backing memory with a fixed three-cycle acknowledge
  logic [DW-1:0] bmem [MEMSZ];
  int  lat_cnt;
  int  ev_total;
  bit  ev_we [4];
  int  ev_ba [4];

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (rst) begin
      lat_cnt  <= 0;
      ev_total <= 0;
      for (int i = 0; i < MEMSZ; i++) bmem[i] <= init_word(i);
    end else if (mem_req && !mem_ack) begin
      if (lat_cnt == 2) begin
        lat_cnt <= 0;
        mem_ack <= 1'b1;
        ev_we[ev_total % 4] <= mem_we;
        ev_ba[ev_total % 4] <= int'(mem_addr);
        ev_total <= ev_total + 1;
        for (int k = 0; k < WORDS; k++) begin
          if (mem_we) bmem[int'(mem_addr) * WORDS + k] <= mem_wdata[k*DW +: DW];
          else        mem_rdata[k*DW +: DW] <= bmem[int'(mem_addr) * WORDS + k];
        end
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end
  end

  // program view of memory and reference cache state
  logic [DW-1:0] gold [MEMSZ];
  int  rt_tag   [NS][NW];
  bit  rt_val   [NS][NW];
  bit  rt_dirty [NS][NW];
  int  rt_age   [NS][NW];

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] last_rd;
  int last_lat;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic touch(int s, int w);
    int cur = rt_age[s][w];
    for (int v = 0; v < NW; v++) begin
      if (v == w) rt_age[s][v] = 0;
      else if (rt_age[s][v] < cur) rt_age[s][v] = rt_age[s][v] + 1;
    end
  endtask

  function automatic int mk(int tag, int set, int off);
    return (tag << (OFF_W + IDX_W)) | (set << OFF_W) | off;
  endfunction

  task automatic access(bit we, int addr, logic [DW-1:0] wd);
    int s    = (addr >> OFF_W) % NS;
    int tag  = addr >> (OFF_W + IDX_W);
    int hw   = -1;
    int vw   = -1;
    int n_exp = 0;
    bit exp_we [2];
    int exp_ba [2];
    int start;
    int lat = 0;
    int n;
    bit exp_hit;
    bit wb = 1'b0;
    int wb_ba = 0;
    logic [DW-1:0] pre;

    for (int w = 0; w < NW; w++)
      if (rt_val[s][w] && rt_tag[s][w] == tag) hw = w;
    exp_hit = (hw >= 0);
    if (!exp_hit) begin
      for (int w = NW - 1; w >= 0; w--) if (!rt_val[s][w]) vw = w;
      if (vw < 0) for (int w = 0; w < NW; w++) if (rt_age[s][w] == NW - 1) vw = w;
      if (rt_val[s][vw] && rt_dirty[s][vw]) begin
        wb = 1'b1;
        wb_ba = rt_tag[s][vw] * NS + s;
        exp_we[n_exp] = 1'b1; exp_ba[n_exp] = wb_ba; n_exp++;
      end
      exp_we[n_exp] = 1'b0; exp_ba[n_exp] = addr >> OFF_W; n_exp++;
    end

    pre   = bmem[addr];
    start = ev_total;
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = AW'(addr); cpu_wdata = wd;
    while (!cpu_ready) @(negedge clk);
    @(posedge clk);
    forever begin
      @(negedge clk);
      cpu_valid = 1'b0;
      lat++;
      if (lat == 1 && !exp_hit) chk("R11 ready low during miss", cpu_ready, 0);
      if (cpu_resp_valid || lat > 400) break;
    end
    last_rd  = cpu_rdata;
    last_lat = lat;

    if (exp_hit) chk("R2/R8 hit answered next cycle", lat, 1);
    else         chk("R3/R6 miss takes longer than a hit", lat > 1, 1);
    n = ev_total - start;
    chk("R10 transfers per access", n, n_exp);
    if (n == n_exp) begin
      for (int i = 0; i < n; i++) begin
        chk("R7 transfer kind and order", ev_we[(start + i) % 4], exp_we[i]);
        chk("R1 transfer block address", ev_ba[(start + i) % 4], exp_ba[i]);
      end
    end
    if (!we) chk("R12 read data", cpu_rdata, gold[addr]);
    if (we && exp_hit) chk("R4 memory untouched by write hit", bmem[addr], pre);
    if (wb) begin
      for (int k = 0; k < WORDS; k++)
        chk("R7 full victim block written", bmem[wb_ba * WORDS + k], gold[wb_ba * WORDS + k]);
    end

    if (exp_hit) begin
      touch(s, hw);
      if (we) rt_dirty[s][hw] = 1'b1;
    end else begin
      rt_val[s][vw]   = 1'b1;
      rt_tag[s][vw]   = tag;
      rt_dirty[s][vw] = we;
      touch(s, vw);
    end
    if (we) gold[addr] = wd;
  endtask

  initial begin
    for (int i = 0; i < MEMSZ; i++) gold[i] = init_word(i);
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        rt_val[s][w] = 1'b0; rt_dirty[s][w] = 1'b0; rt_age[s][w] = w; rt_tag[s][w] = 0;
      end
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: state after reset
    chk("R9 ready after reset", cpu_ready, 1);
    chk("R9 no response after reset", cpu_resp_valid, 0);
    chk("R9 no memory request after reset", mem_req, 0);

    // R9/R3: first read misses, second read of same block hits
    access(0, mk(1, 0, 3), '0);
    access(0, mk(1, 0, 5), '0);
    chk("R3 block installed by read miss", last_lat, 1);
    // R4: write hit leaves memory alone
    access(1, mk(1, 0, 5), 32'hCAFE_0001);
    access(0, mk(1, 0, 5), '0);
    chk("R4 write hit visible in cache", last_rd, 32'hCAFE_0001);
    // R6: second tag fills the free way without evicting tag 1
    access(0, mk(2, 0, 0), '0);
    access(0, mk(1, 0, 1), '0);
    chk("R6 free way used, older block kept", last_lat, 1);
    // R8: tag 1 just touched, so tag 2 is evicted (clean, no write)
    access(0, mk(3, 0, 2), '0);
    access(0, mk(1, 0, 6), '0);
    chk("R8 recently used block survives", last_lat, 1);
    // R7: bring tag 2 back; victim is tag 3 (clean). Then evict dirty tag 1.
    access(0, mk(2, 0, 0), '0);
    access(0, mk(5, 0, 4), '0);
    // R1: another set is independent
    access(0, mk(1, 2, 0), '0);
    access(0, mk(5, 0, 4), '0);
    chk("R1 other set leaves this set intact", last_lat, 1);
    // R5: write miss allocates and merges
    access(1, mk(4, 1, 7), 32'hBEEF_0002);
    access(0, mk(4, 1, 7), '0);
    chk("R5 write miss merged into block", last_rd, 32'hBEEF_0002);
    chk("R5 write miss allocated block", last_lat, 1);

    // constrained random mix
    for (int i = 0; i < 2500; i++) begin
      bit we = ($urandom % 3) == 0;
      int a  = mk($urandom % 5, $urandom % NS, $urandom % WORDS);
      access(we, a, $urandom);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule